// File: doc/BRIEF.md
# Flash Program/Erase Timing Controller

This block schedules program and erase operations on an embedded flash array and decides when the processor may touch the array. A programmable timebase gives the number of undivided system clock cycles in a 5 µs interval, minus one. The controller turns that value into a 5 µs tick. Byte writes, sector erases and mass erases are then timed as fixed numbers of these ticks. Software starts an operation through a small register write port. The block raises `busy` for the whole operation and raises `done` for one cycle when the operation ends.

The system clock divider setting is an input. The timebase is always given in undivided cycles. Whenever the divider code changes, the controller rescales its internal tick reload, so an operation keeps the same wall-clock length. The timebase can be written only while the divider is at divide-by-one. While the slow subclock drives the system, no scaling is possible, so start requests are refused.

The processor's flash port gets a ready/stall output. Reads take no wait states while writing is disabled and two wait states once writing is enabled. Any access made during an operation is stalled until the operation finishes.

Top module: `flash_pe_timer`

## Requirements
- R1: After reset, `busy` and `done` are low, `bus_ready` is high with no access pending, write enable is clear, and the timebase holds 199. A byte write started straight after reset therefore lasts 6 × 200 = 1200 cycles.
- R2: A configuration write with `cfg_sel` = 0 loads the timebase from `cfg_wdata` only when `clk_div` is 0. With any other divider code the write is ignored.
- R3: For divider code n, the tick period is R+1 cycles, where R = ((timebase+1) >> n) − 1, with a floor of 0.
- R4: A configuration write with `cfg_sel` = 1 and `cfg_wdata[1:0]` = 1, 2 or 3 starts a byte write (6 ticks), a sector erase (2000 ticks) or a mass erase (40000 ticks). `busy` then stays high for exactly ticks × (R+1) cycles, counted from the cycle after the start edge. Code 0 starts nothing.
- R5: `done` is high for exactly one cycle. That cycle is the first cycle in which `busy` is low again after an operation.
- R6: A start request made while `busy` is high is ignored. The running operation ends at its original time, and no second operation follows.
- R7: While `subclk_sel` is high, a start request is rejected and `busy` stays low.
- R8: With write enable clear and no operation running, `bus_ready` is high in the first cycle of a read.
- R9: With write enable set, a read sees `bus_ready` low for exactly two cycles and then high. Each back-to-back read pays the two cycles again. Writes pay no wait states.
- R10: While `busy` is high, `bus_ready` is low for reads and for writes.
- R11: A configuration write with `cfg_sel` = 2 sets write enable from `cfg_wdata[0]`. `cfg_sel` = 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 timebase, 1 operation start, 2 write enable |
| cfg_wdata | input | 16 | Configuration write data |
| clk_div | input | 3 | System clock divider code (divide by 2^n) |
| subclk_sel | input | 1 | High while the slow subclock is the system clock |
| bus_req | input | 1 | Processor flash access request, held until ready |
| bus_wr | input | 1 | Access is a write |
| bus_ready | output | 1 | Access completes this cycle; low means wait state |
| busy | output | 1 | Program or erase operation in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
The hardest case to reach is a divider change. It must show up in operation length, and only as the rescaled reload, never as a changed stored timebase. The bench loads a timebase at divide-by-one and then moves the divider up. It includes a code whose shift gives zero, to reach the floor. Next it tries a timebase write at a non-unity divider and returns to divide-by-one. The length of the following byte write shows whether the ignored value leaked in. Starts made in the middle of a running operation are injected at a chosen tick offset. The bench then measures the total busy span, which shows whether the operation was restarted.

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
  parameter int TB_W         = 16,
  parameter int DIV_W        = 3,
  parameter int OPC_W        = 16,
  parameter int BYTE_TICKS   = 6,
  parameter int SECTOR_TICKS = 2000,
  parameter int MASS_TICKS   = 40000,
  parameter int RD_WAIT      = 2,
  parameter int TB_RESET     = 199
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [TB_W-1:0]  cfg_wdata,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             subclk_sel,
  input  logic             bus_req,
  input  logic             bus_wr,
  output logic             bus_ready,
  output logic             busy,
  output logic             done
);
  localparam int WS_W = (RD_WAIT < 1) ? 1 : $clog2(RD_WAIT + 1);
  localparam logic [1:0] SEL_TB  = 2'd0;
  localparam logic [1:0] SEL_CMD = 2'd1;
  localparam logic [1:0] SEL_WE  = 2'd2;

  logic [TB_W-1:0]  tb_q;
  logic [TB_W-1:0]  pre_q;
  logic [TB_W-1:0]  reload;
  logic [TB_W:0]    tb_plus;
  logic [TB_W:0]    scaled;
  logic [OPC_W-1:0] ops_q;
  logic [OPC_W-1:0] op_len;
  logic [WS_W-1:0]  ws_q;
  logic             we_q;
  logic             busy_q;
  logic             done_q;
  logic             tick;
  logic             start_ok;
  logic             rd_waiting;

  assign tb_plus = {1'b0, tb_q} + 1'b1;
  assign scaled  = tb_plus >> clk_div;
  assign reload  = (scaled == '0) ? '0 : TB_W'(scaled - 1'b1);

  always_comb begin
    case (cfg_wdata[1:0])
      2'd1:    op_len = OPC_W'(BYTE_TICKS);
      2'd2:    op_len = OPC_W'(SECTOR_TICKS);
      2'd3:    op_len = OPC_W'(MASS_TICKS);
      default: op_len = '0;
    endcase
  end

  assign start_ok = cfg_we && (cfg_sel == SEL_CMD) && (cfg_wdata[1:0] != 2'd0)
                    && !busy_q && !subclk_sel;
  assign tick     = busy_q && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q <= TB_W'(TB_RESET);
      we_q <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_TB && clk_div == '0) tb_q <= cfg_wdata;
      if (cfg_sel == SEL_WE) we_q <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pre_q  <= '0;
      ops_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        pre_q  <= reload;
        ops_q  <= op_len;
      end else if (busy_q) begin
        pre_q <= tick ? reload : pre_q - 1'b1;
        if (tick) begin
          if (ops_q <= OPC_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ops_q  <= '0;
          end else begin
            ops_q <= ops_q - 1'b1;
          end
        end
      end
    end
  end

  assign rd_waiting = bus_req && !bus_wr && we_q && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  ws_q <= '0;
    else if (!rd_waiting)                        ws_q <= '0;
    else if (ws_q == WS_W'(RD_WAIT))             ws_q <= '0;
    else                                         ws_q <= ws_q + 1'b1;
  end

  assign bus_ready = !busy_q && (bus_wr || !we_q || ws_q == WS_W'(RD_WAIT));
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/flash_pe_timer_chk.sv
module flash_pe_timer_chk #(
  parameter int TB_W  = 16,
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [DIV_W-1:0] clk_div,
  input logic             subclk_sel,
  input logic             bus_req,
  input logic             bus_wr,
  input logic             bus_ready,
  input logic             busy,
  input logic             done,
  input logic             we_q,
  input logic [TB_W-1:0]  tb_q,
  input logic [TB_W-1:0]  pre_q,
  input logic [TB_W-1:0]  reload
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R5
  AST_TB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0 && clk_div != '0) |=> $stable(tb_q)); // R2
  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $stable(clk_div) && $past(busy)) |-> pre_q <= reload); // R3
  AST_SUBCLK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && subclk_sel) |=> !busy); // R7
  AST_ZERO_WAIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && !we_q && !busy) |-> bus_ready); // R8
  AST_FIRST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && !bus_wr && we_q && !busy) |-> !bus_ready); // R9
endmodule

bind flash_pe_timer flash_pe_timer_chk #(.TB_W(TB_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .clk_div(clk_div),
  .subclk_sel(subclk_sel), .bus_req(bus_req), .bus_wr(bus_wr), .bus_ready(bus_ready),
  .busy(busy), .done(done), .we_q(we_q), .tb_q(tb_q), .pre_q(pre_q), .reload(reload)
);

// File: tb/flash_pe_timer_tb.sv
`timescale 1ns/100ps
module flash_pe_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [2:0]  clk_div = 3'd0;
  logic        subclk_sel = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_ready, busy, done;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_pe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .clk_div(clk_div), .subclk_sel(subclk_sel), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_ready(bus_ready), .busy(busy), .done(done)
  );

  // behavioural reference
  int m_tb = 199;
  bit m_we = 0;
  bit m_busy = 0;
  bit m_done = 0;
  int m_left = 0;
  int m_waited = 0;

  function automatic int tick_len(int tb, int dv);
    int r;
    r = ((tb + 1) >> dv) - 1;
    if (r < 0) r = 0;
    return r + 1;
  endfunction

  function automatic int op_ticks(int code);
    case (code)
      1: return 6;
      2: return 2000;
      3: return 40000;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_ready();
    return !m_busy && (bus_wr || !m_we || m_waited >= 2);
  endfunction

  always @(posedge clk) begin
    bit rdy;
    if (!rst_n) begin
      m_tb = 199; m_we = 0; m_busy = 0; m_done = 0; m_left = 0; m_waited = 0;
    end else begin
      rdy = m_ready();
      if (bus_req && !bus_wr && m_we && !m_busy && !rdy) m_waited++;
      else m_waited = 0;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (cfg_we && cfg_sel == 2'd1 && cfg_wdata[1:0] != 0 && !subclk_sel) begin
        m_busy = 1;
        m_left = op_ticks(int'(cfg_wdata[1:0])) * tick_len(m_tb, int'(clk_div));
      end
      if (cfg_we && cfg_sel == 2'd0 && clk_div == 0) m_tb = int'(cfg_wdata);
      if (cfg_we && cfg_sel == 2'd2) m_we = cfg_wdata[0];
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 busy", busy, m_busy);
      check("R5 done", done, m_done);
      check("R10 bus_ready", bus_ready, m_ready());
    end
  end

  task automatic cfg_write(logic [1:0] sel, logic [15:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // starts an op, optionally injects a start at cycle intr_at, returns busy span
  task automatic run_op(int code, int intr_at, output int span);
    int k = 0;
    span = 0;
    cfg_write(2'd1, 16'(code));
    forever begin
      @(negedge clk);
      if (done) break;
      if (busy) span++;
      if (k == intr_at) begin cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'd3; end
      else cfg_we = 1'b0;
      k++;
      if (k > 60000) break;
    end
    cfg_we = 1'b0;
  endtask

  task automatic do_access(bit wr, output int waits);
    waits = 0;
    @(posedge clk); #1;
    bus_req = 1'b1; bus_wr = wr;
    forever begin
      @(negedge clk);
      if (bus_ready) break;
      waits++;
      if (waits > 100) break;
    end
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int span, w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 ready after reset", bus_ready, 1);

    run_op(1, -1, span); check("R1 default timebase byte write", span, 1200);

    cfg_write(2'd0, 16'd0);
    run_op(1, -1, span); check("R4 byte write", span, 6);
    run_op(2, -1, span); check("R4 sector erase", span, 2000);
    run_op(3, -1, span); check("R4 mass erase", span, 40000);

    cfg_write(2'd1, 16'd0);
    repeat (3) @(negedge clk);
    check("R4 code 0 starts nothing", busy, 0);

    cfg_write(2'd0, 16'd3);
    @(posedge clk); #1 clk_div = 3'd1;
    run_op(1, -1, span); check("R3 divide by 2", span, 12);
    @(posedge clk); #1 clk_div = 3'd3;
    run_op(1, -1, span); check("R3 floor at zero", span, 6);

    @(posedge clk); #1 clk_div = 3'd1;
    cfg_write(2'd0, 16'd9);
    @(posedge clk); #1 clk_div = 3'd0;
    run_op(1, -1, span); check("R2 ignored timebase write", span, 24);

    run_op(1, 3, span); check("R6 start while busy", span, 24);
    repeat (2) @(negedge clk);
    check("R6 no follow-on op", busy, 0);

    @(posedge clk); #1 subclk_sel = 1'b1;
    cfg_write(2'd1, 16'd1);
    repeat (4) @(negedge clk);
    check("R7 subclock reject", busy, 0);
    @(posedge clk); #1 subclk_sel = 1'b0;

    do_access(1'b0, w); check("R8 read zero wait", w, 0);
    cfg_write(2'd3, 16'd1);
    do_access(1'b0, w); check("R11 sel 3 no effect", w, 0);
    cfg_write(2'd2, 16'd1);
    do_access(1'b0, w); check("R9 read two waits", w, 2);
    do_access(1'b0, w); check("R9 repeat read two waits", w, 2);
    do_access(1'b1, w); check("R9 write zero wait", w, 0);

    cfg_write(2'd1, 16'd1);
    @(posedge clk); #1 bus_req = 1'b1; bus_wr = 1'b0;
    @(negedge clk); check("R10 read stalled while busy", bus_ready, 0);
    @(posedge clk); #1 bus_wr = 1'b1;
    @(negedge clk); check("R10 write stalled while busy", bus_ready, 0);
    @(posedge clk); #1 bus_req = 1'b0; bus_wr = 1'b0;
    repeat (40) @(posedge clk);

    cfg_write(2'd2, 16'd0);
    do_access(1'b0, w); check("R11 write enable cleared", w, 0);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule